// File: doc/BRIEF.md
# Text Overlay Generator

This block lays a grid of characters over an incoming video raster. It counts dot clocks after each horizontal sync and scan lines after each vertical sync. From those counts it places a grid of `ROWS` by `COLS` character cells at a programmable offset. For every dot inside the grid it fetches the cell's character code, reads the matching glyph row from an internal font table and picks the dot for the current column. Where the dot is lit, it drives a colour and a keying signal that tells the downstream mixer to replace the background video.

A processor writes the character codes, one byte per cell, through a simple write port on its own clock. The same port writes the per-row foreground colours, the two grid offsets and a bar configuration. The bar configuration splits one chosen row into two colours at a programmable column, which draws a level indicator such as a volume bar. The dot counter is held at zero for as long as horizontal sync is high, so the pixel phase is realigned on every line.

Top module: `osd_overlay`

## Requirements
- R1: After reset all four video outputs are 0, every row colour is 0, both offsets are 0 and the bar is disabled.
- R2: A write to address a, with a below ROWS*COLS, stores wr_data[6:0] as the code of cell row a/COLS, column a%COLS; wr_data[7] is dropped.
- R3: Glyph dot i (i=0 is leftmost) on glyph line l of code c is lit when c is not 0 and bit ((i+l) mod 8) of the byte {1'b1, c[6:0]} is 1; code 0 is blank.
- R4: Counting from the first dot-clock edge that samples hsync low as edge 1, grid dot p (0 to COLS*GW-1) of a line appears at the outputs after edge h_start+2+p; while hsync is high the outputs show background and the count restarts.
- R5: After vsync is sampled high and released, grid line L (0 to ROWS*GH-1) is shown on the line that follows hsync pulse number v_start+1+L; vsync restarts the line count.
- R6: Address ROWS*COLS+r holds the colour of row r in bits 2:0, driven to vid_r, vid_g and vid_b from bit 2 down to bit 0.
- R7: Address ROWS*COLS+ROWS holds the bar enable in bit 7 and the bar row in the low bits; address +1 holds the split column and +2 the second colour; when enabled, cells of the bar row at columns at or above the split use the second colour and the rest use the row colour.
- R8: vid_blank is 1 only for a lit glyph dot inside the grid, and vid_r, vid_g and vid_b are 0 whenever vid_blank is 0.
- R9: Address ROWS*COLS+ROWS+3 holds the 8-bit horizontal offset h_start and address ROWS*COLS+ROWS+4 the 8-bit vertical offset v_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Clock of the write port |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Cell or register address |
| wr_data | input | 8 | Write data |
| dot_clk | input | 1 | Dot clock of the video raster |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| vid_r | output | 1 | Red overlay output |
| vid_g | output | 1 | Green overlay output |
| vid_b | output | 1 | Blue overlay output |
| vid_blank | output | 1 | High where the overlay replaces the background |

## Verification
The bench uses the default build: 8 rows by 20 columns of 11 by 15 dot glyphs, with a 9-bit address. At this size every dot of a full frame can be compared, and three frames are swept dot by dot. The first frame runs with the reset configuration. The second uses small offsets and a mid-row bar split. The third uses a large horizontal offset, a different bar row and split, and a rewritten code table in which bit 7 is set on every write. Every cell, every glyph line and column, every row colour and both sides of each split are compared against a model the bench computes arithmetically.

// File: rtl/osd_pkg.sv
package osd_pkg;

   localparam int CODE_W = 7;
   localparam int ROM_W  = 16;
   localparam int OFS_W  = 8;
   localparam int DATA_W = 8;

   typedef logic [2:0] rgb_t;

   // Test font: code 0 is blank, any other code lights dot i of line l
   // when bit ((i+l) mod 8) of {1, code} is set; dots beyond width stay 0.
   function automatic logic [ROM_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                  input logic [3:0]        line,
                                                  input int                width);
      logic [7:0]       ext;
      logic [ROM_W-1:0] row;
      logic [2:0]       sel;
      ext = {1'b1, code};
      row = '0;
      case (code)
         7'd0: row = '0;
         default: begin
            for (int i = 0; i < ROM_W; i++) begin
               sel = 3'(i + int'(line));
               if (i < width) row[i] = ext[sel];
            end
         end
      endcase
      return row;
   endfunction

endpackage

// File: rtl/osd_regs.sv
module osd_regs #(
   parameter int ROWS   = 8,
   parameter int COLS   = 20,
   parameter int ADDR_W = 9
) (
   input  logic                                 cpu_clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [osd_pkg::DATA_W-1:0]           wr_data,
   input  logic [$clog2(ROWS*COLS)-1:0]         rd_idx,
   output logic [osd_pkg::CODE_W-1:0]           rd_code,
   output logic [ROWS-1:0][2:0]                 row_colour,
   output logic                                 bar_en,
   output logic [$clog2(ROWS)-1:0]              bar_row,
   output logic [$clog2(COLS)-1:0]              bar_split,
   output logic [2:0]                           bar_colour,
   output logic [osd_pkg::OFS_W-1:0]            h_start,
   output logic [osd_pkg::OFS_W-1:0]            v_start
);
   localparam int NCELL   = ROWS * COLS;
   localparam int IDX_W   = $clog2(NCELL);
   localparam int ROW_W   = $clog2(ROWS);
   localparam int COL_W   = $clog2(COLS);
   localparam int A_COL   = NCELL;
   localparam int A_BAR   = NCELL + ROWS;
   localparam int A_SPLIT = A_BAR + 1;
   localparam int A_BARC  = A_BAR + 2;
   localparam int A_HST   = A_BAR + 3;
   localparam int A_VST   = A_BAR + 4;

   logic [osd_pkg::CODE_W-1:0] code_mem [NCELL];

   always_ff @(posedge cpu_clk) begin
      if (wr_en && wr_addr < ADDR_W'(NCELL))
         code_mem[wr_addr[IDX_W-1:0]] <= wr_data[osd_pkg::CODE_W-1:0];
   end

   assign rd_code = code_mem[rd_idx];

   always_ff @(posedge cpu_clk) begin
      if (!rst_n) begin
         row_colour <= '0;
         bar_en     <= 1'b0;
         bar_row    <= '0;
         bar_split  <= '0;
         bar_colour <= '0;
         h_start    <= '0;
         v_start    <= '0;
      end else if (wr_en) begin
         for (int r = 0; r < ROWS; r++)
            if (wr_addr == ADDR_W'(A_COL + r)) row_colour[r] <= wr_data[2:0];
         if (wr_addr == ADDR_W'(A_BAR)) begin
            bar_en  <= wr_data[7];
            bar_row <= wr_data[ROW_W-1:0];
         end
         if (wr_addr == ADDR_W'(A_SPLIT)) bar_split  <= wr_data[COL_W-1:0];
         if (wr_addr == ADDR_W'(A_BARC))  bar_colour <= wr_data[2:0];
         if (wr_addr == ADDR_W'(A_HST))   h_start    <= wr_data;
         if (wr_addr == ADDR_W'(A_VST))   v_start    <= wr_data;
      end
   end

   AST_ROWCOL_LOAD: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(A_COL)) |=> (row_colour[0] == $past(wr_data[2:0]))); // R6
   AST_HSTART_LOAD: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(A_HST)) |=> (h_start == $past(wr_data))); // R9
   AST_CELL_NO_CFG: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (wr_en && wr_addr < ADDR_W'(NCELL)) |=> $stable(row_colour) && $stable(h_start) && $stable(v_start)); // R2

endmodule

// File: rtl/osd_timing.sv
module osd_timing #(
   parameter int ROWS = 8,
   parameter int COLS = 20,
   parameter int GW   = 11,
   parameter int GH   = 15
) (
   input  logic                          dot_clk,
   input  logic                          rst_n,
   input  logic                          hsync,
   input  logic                          vsync,
   input  logic [osd_pkg::OFS_W-1:0]     h_start,
   input  logic [osd_pkg::OFS_W-1:0]     v_start,
   output logic                          h_act,
   output logic                          v_act,
   output logic [$clog2(GW)-1:0]         px,
   output logic [$clog2(COLS)-1:0]       col,
   output logic [$clog2(GH)-1:0]         ln,
   output logic [$clog2(ROWS)-1:0]       row
);
   localparam int POS_W = osd_pkg::OFS_W + 1;
   localparam int PX_W  = $clog2(GW);
   localparam int COL_W = $clog2(COLS);
   localparam int LN_W  = $clog2(GH);
   localparam int ROW_W = $clog2(ROWS);

   logic [POS_W-1:0] hpos, vpos;
   logic             hs_q;
   logic             line_tick;

   assign line_tick = hsync & ~hs_q;

   // Horizontal: held while sync is high, restarts with it (phase realign).
   always_ff @(posedge dot_clk) begin
      if (!rst_n) begin
         hs_q  <= 1'b0;
         hpos  <= '0;
         h_act <= 1'b0;
         px    <= '0;
         col   <= '0;
      end else begin
         hs_q <= hsync;
         if (hsync) begin
            hpos  <= '0;
            h_act <= 1'b0;
            px    <= '0;
            col   <= '0;
         end else begin
            if (hpos != '1) hpos <= hpos + 1'b1;
            if (hpos == {1'b0, h_start}) begin
               h_act <= 1'b1;
               px    <= '0;
               col   <= '0;
            end else if (h_act) begin
               if (px == PX_W'(GW - 1)) begin
                  px <= '0;
                  if (col == COL_W'(COLS - 1)) h_act <= 1'b0;
                  else                         col   <= col + 1'b1;
               end else begin
                  px <= px + 1'b1;
               end
            end
         end
      end
   end

   // Vertical: advanced once per sync pulse, cleared by vertical sync.
   always_ff @(posedge dot_clk) begin
      if (!rst_n) begin
         vpos  <= '0;
         v_act <= 1'b0;
         ln    <= '0;
         row   <= '0;
      end else if (vsync) begin
         vpos  <= '0;
         v_act <= 1'b0;
         ln    <= '0;
         row   <= '0;
      end else if (line_tick) begin
         if (vpos != '1) vpos <= vpos + 1'b1;
         if (vpos == {1'b0, v_start}) begin
            v_act <= 1'b1;
            ln    <= '0;
            row   <= '0;
         end else if (v_act) begin
            if (ln == LN_W'(GH - 1)) begin
               ln <= '0;
               if (row == ROW_W'(ROWS - 1)) v_act <= 1'b0;
               else                         row   <= row + 1'b1;
            end else begin
               ln <= ln + 1'b1;
            end
         end
      end
   end

   AST_HSYNC_IDLE: assert property (@(posedge dot_clk) disable iff (!rst_n)
      hsync |=> !h_act); // R4
   AST_VSYNC_IDLE: assert property (@(posedge dot_clk) disable iff (!rst_n)
      vsync |=> !v_act); // R5
   AST_ROW_HOLD: assert property (@(posedge dot_clk) disable iff (!rst_n)
      (!vsync && !line_tick) |=> ($stable(row) && $stable(ln) && $stable(v_act))); // R5

endmodule

// File: rtl/osd_pixel.sv
module osd_pixel #(
   parameter int ROWS = 8,
   parameter int COLS = 20,
   parameter int GW   = 11,
   parameter int GH   = 15
) (
   input  logic                              dot_clk,
   input  logic                              rst_n,
   input  logic                              h_act,
   input  logic                              v_act,
   input  logic [$clog2(GW)-1:0]             px,
   input  logic [$clog2(COLS)-1:0]           col,
   input  logic [$clog2(GH)-1:0]             ln,
   input  logic [$clog2(ROWS)-1:0]           row,
   output logic [$clog2(ROWS*COLS)-1:0]      cell_idx,
   input  logic [osd_pkg::CODE_W-1:0]        code,
   input  logic [ROWS-1:0][2:0]              row_colour,
   input  logic                              bar_en,
   input  logic [$clog2(ROWS)-1:0]           bar_row,
   input  logic [$clog2(COLS)-1:0]           bar_split,
   input  logic [2:0]                        bar_colour,
   output logic                              vid_r,
   output logic                              vid_g,
   output logic                              vid_b,
   output logic                              vid_blank
);
   localparam int IDX_W = $clog2(ROWS * COLS);

   logic [osd_pkg::ROM_W-1:0] glyph;
   logic                      dot_on;
   logic                      use_b;
   osd_pkg::rgb_t             colour;

   assign cell_idx = IDX_W'(int'(row) * COLS + int'(col));
   assign glyph    = osd_pkg::glyph_row(code, 4'(ln), GW);
   assign dot_on   = h_act & v_act & glyph[px];
   assign use_b    = bar_en && (bar_row == row) && (col >= bar_split);
   assign colour   = use_b ? bar_colour : row_colour[row];

   always_ff @(posedge dot_clk) begin
      if (!rst_n) begin
         {vid_r, vid_g, vid_b} <= 3'b000;
         vid_blank             <= 1'b0;
      end else begin
         {vid_r, vid_g, vid_b} <= dot_on ? colour : 3'b000;
         vid_blank             <= dot_on;
      end
   end

   AST_BG_OUTSIDE: assert property (@(posedge dot_clk) disable iff (!rst_n)
      !(h_act && v_act) |=> (!vid_blank && !vid_r && !vid_g && !vid_b)); // R8
   AST_COLOUR_KEYED: assert property (@(posedge dot_clk) disable iff (!rst_n)
      (vid_r || vid_g || vid_b) |-> vid_blank); // R8
   AST_BAR_PICK: assert property (@(posedge dot_clk) disable iff (!rst_n)
      (dot_on && bar_en && bar_row == row && col >= bar_split)
         |=> ({vid_r, vid_g, vid_b} == $past(bar_colour))); // R7

endmodule

// File: rtl/osd_overlay.sv
module osd_overlay #(
   parameter int ROWS   = 8,
   parameter int COLS   = 20,
   parameter bit HIRES  = 1'b1,
   parameter int ADDR_W = 9
) (
   input  logic                        cpu_clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [7:0]                  wr_data,
   input  logic                        dot_clk,
   input  logic                        hsync,
   input  logic                        vsync,
   output logic                        vid_r,
   output logic                        vid_g,
   output logic                        vid_b,
   output logic                        vid_blank
);
   localparam int GW    = HIRES ? 11 : 5;
   localparam int GH    = HIRES ? 15 : 7;
   localparam int NCELL = ROWS * COLS;
   localparam int NREG  = NCELL + ROWS + 5;
   localparam int IDX_W = $clog2(NCELL);
   localparam int PX_W  = $clog2(GW);
   localparam int COL_W = $clog2(COLS);
   localparam int LN_W  = $clog2(GH);
   localparam int ROW_W = $clog2(ROWS);

   if (ROWS < 2 || ROW_W > 7) begin : g_bad_rows
      $error("ROWS must lie between 2 and 128");
   end
   if (COLS < 2 || COL_W > 8) begin : g_bad_cols
      $error("COLS must lie between 2 and 256");
   end
   if ((64'd1 << ADDR_W) < 64'(NREG) || ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the cell and register space");
   end

   logic [IDX_W-1:0]                  cell_idx;
   logic [osd_pkg::CODE_W-1:0]        code;
   logic [ROWS-1:0][2:0]              row_colour;
   logic                              bar_en;
   logic [ROW_W-1:0]                  bar_row;
   logic [COL_W-1:0]                  bar_split;
   logic [2:0]                        bar_colour;
   logic [osd_pkg::OFS_W-1:0]         h_start, v_start;
   logic                              h_act, v_act;
   logic [PX_W-1:0]                   px;
   logic [COL_W-1:0]                  col;
   logic [LN_W-1:0]                   ln;
   logic [ROW_W-1:0]                  row;

   osd_regs #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_regs (
      .cpu_clk    (cpu_clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_idx     (cell_idx),
      .rd_code    (code),
      .row_colour (row_colour),
      .bar_en     (bar_en),
      .bar_row    (bar_row),
      .bar_split  (bar_split),
      .bar_colour (bar_colour),
      .h_start    (h_start),
      .v_start    (v_start)
   );

   osd_timing #(.ROWS(ROWS), .COLS(COLS), .GW(GW), .GH(GH)) u_timing (
      .dot_clk (dot_clk),
      .rst_n   (rst_n),
      .hsync   (hsync),
      .vsync   (vsync),
      .h_start (h_start),
      .v_start (v_start),
      .h_act   (h_act),
      .v_act   (v_act),
      .px      (px),
      .col     (col),
      .ln      (ln),
      .row     (row)
   );

   osd_pixel #(.ROWS(ROWS), .COLS(COLS), .GW(GW), .GH(GH)) u_pixel (
      .dot_clk    (dot_clk),
      .rst_n      (rst_n),
      .h_act      (h_act),
      .v_act      (v_act),
      .px         (px),
      .col        (col),
      .ln         (ln),
      .row        (row),
      .cell_idx   (cell_idx),
      .code       (code),
      .row_colour (row_colour),
      .bar_en     (bar_en),
      .bar_row    (bar_row),
      .bar_split  (bar_split),
      .bar_colour (bar_colour),
      .vid_r      (vid_r),
      .vid_g      (vid_g),
      .vid_b      (vid_b),
      .vid_blank  (vid_blank)
   );

endmodule

// File: tb/osd_overlay_tb.sv
module osd_overlay_tb;
   localparam int ROWS  = 8;
   localparam int COLS  = 20;
   localparam int GW    = 11;
   localparam int GH    = 15;
   localparam int NCELL = ROWS * COLS;
   localparam int AW    = 9;

   logic clk = 1'b0;
   logic rst_n, wr_en, hsync, vsync;
   logic [AW-1:0] wr_addr;
   logic [7:0] wr_data;
   logic vid_r, vid_g, vid_b, vid_blank;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [6:0] m_code [NCELL];
   logic [2:0] m_rowc [ROWS];
   bit         m_bar_en;
   int         m_bar_row, m_split, m_hst, m_vst;
   logic [2:0] m_barc;

   always #5 clk = ~clk;

   osd_overlay #(.ROWS(ROWS), .COLS(COLS), .HIRES(1'b1), .ADDR_W(AW)) u_dut (
      .cpu_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dot_clk(clk), .hsync(hsync), .vsync(vsync),
      .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b), .vid_blank(vid_blank)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp,
                        input int line, input int dot);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s line %0d dot %0d: actual %b expected %b", tag, line, dot, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // R2: cell codes, bit 7 may be set and must be dropped
   task automatic load_codes(input int mul, input int add, input int zmod, input int zval, input bit b7);
      for (int k = 0; k < NCELL; k++) begin
         int c;
         c = (k * mul + add) % 128;
         if (k % zmod == zval) c = 0;
         m_code[k] = 7'(c);
         wr(k, b7 ? (c | 128) : c);
      end
   endtask

   // Expected {blank,r,g,b} for grid line L, grid dot p (R3 R6 R7 R8)
   function automatic logic [3:0] model(input int L, input int p);
      int r, l, c, i;
      logic [7:0] ext;
      logic [2:0] colr;
      bit lit;
      if (L < 0 || L >= ROWS * GH || p < 0 || p >= COLS * GW) return 4'b0000;
      r = L / GH; l = L % GH; c = p / GW; i = p % GW;
      ext = {1'b1, m_code[r * COLS + c]};
      lit = (m_code[r * COLS + c] != 7'd0) && ext[(i + l) % 8];
      colr = (m_bar_en && m_bar_row == r && c >= m_split) ? m_barc : m_rowc[r];
      return lit ? {1'b1, colr} : 4'b0000;
   endfunction

   // R4 R5: sweep a whole frame dot by dot
   task automatic run_frame(input string tag);
      int nl, nd;
      nl = m_vst + 1 + ROWS * GH + 1;
      nd = m_hst + 2 + COLS * GW + 3;
      @(negedge clk); vsync = 1'b1;
      repeat (3) @(negedge clk);
      vsync = 1'b0;
      for (int j = 1; j <= nl; j++) begin
         hsync = 1'b1;
         for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check({tag, " R4 sync"}, {vid_blank, vid_r, vid_g, vid_b}, 4'b0000, j, -1);
         end
         hsync = 1'b0;
         for (int k = 1; k <= nd; k++) begin
            @(negedge clk);
            check(tag, {vid_blank, vid_r, vid_g, vid_b}, model(j - m_vst - 1, k - m_hst - 2), j, k);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; hsync = 1'b0; vsync = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         check("R1 reset", {vid_blank, vid_r, vid_g, vid_b}, 4'b0000, 0, s);
      end

      // Frame 0: reset configuration (R1): colours 0, offsets 0, no bar
      for (int r = 0; r < ROWS; r++) m_rowc[r] = 3'b000;
      m_bar_en = 1'b0; m_bar_row = 0; m_split = 0; m_barc = 3'b000; m_hst = 0; m_vst = 0;
      load_codes(37, 5, 9, 0, 1'b0);
      run_frame("R1 R2 R3 R8");

      // Frame 1: small offsets, row colours, mid-row bar split (R6 R7 R9)
      for (int r = 0; r < ROWS; r++) begin
         m_rowc[r] = 3'((r * 3 + 1) % 8);
         wr(NCELL + r, m_rowc[r]);
      end
      m_bar_en = 1'b1; m_bar_row = 5; m_split = 7; m_barc = 3'b101;
      wr(NCELL + ROWS, 128 | 5);
      wr(NCELL + ROWS + 1, 7);
      wr(NCELL + ROWS + 2, 5);
      m_hst = 10; m_vst = 3;
      wr(NCELL + ROWS + 3, 10);
      wr(NCELL + ROWS + 4, 3);
      run_frame("R3 R4 R5 R6 R7 R9");

      // Frame 2: large h offset, bar on last row at last column, new codes with bit 7 set
      load_codes(11, 1, 7, 3, 1'b1);
      m_bar_row = 7; m_split = 19; m_barc = 3'b011;
      wr(NCELL + ROWS, 128 | 7);
      wr(NCELL + ROWS + 1, 19);
      wr(NCELL + ROWS + 2, 3);
      m_hst = 200; m_vst = 1;
      wr(NCELL + ROWS + 3, 200);
      wr(NCELL + ROWS + 4, 1);
      run_frame("R2 R4 R5 R7 R8 R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule